// File: doc/BRIEF.md
# Translation Lookaside Buffer with Access Rights

This block caches page-table mappings. It has 64 entries in 16 sets of 4 ways. A lookup request carries a virtual page number and an access kind. One clock later the block reports one of three results: a hit with the physical page number, a miss, or a protection fault. The low four bits of the virtual page number select the set. The remaining bits are compared against the tag of every valid way in that set.

Each entry holds a tag, a physical page number, a two-bit rights code, and valid, reference and dirty flags. Permitted hits update the reference flags, which feed an approximate least-recently-used replacement choice. A permitted store also marks the entry dirty.

The page walker installs entries through the refill port after a miss. One clock later the block reports the entry that was displaced, including whether it was dirty, so that a write-back can be scheduled. A flush input invalidates the whole table in one cycle.

The control path is a result state machine. The request seen at a clock edge decides the next state:

| Request at the edge | Next state |
|---|---|
| Flush | `RS_FLUSHED` |
| Refill | `RS_FILLED` |
| Lookup with a permitted match | `RS_HIT` |
| Lookup with no valid match | `RS_MISS` |
| Lookup with a match whose rights forbid the access | `RS_FAULT` |
| Nothing | `RS_IDLE` |

Reset enters `RS_IDLE`. The output flags are decoded from the current state.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, every entry is invalid and all result and eviction outputs are 0, so the first lookup misses.
- R2: A lookup is sampled at a clock edge and its result appears after that edge. A match needs a valid way in set `vpn[3:0]` whose tag equals `vpn[19:4]`. On a permitted match, `lk_hit` is 1 and `lk_ppn` carries the stored page number.
- R3: A lookup with no valid matching way raises only `lk_miss`, drives `lk_ppn` to 0 and changes no entry.
- R4: The rights code and the access kind decide whether a matching lookup is permitted:
  - Rights codes: 00 none, 01 read-only, 10 read/write, 11 executable.
  - Access kinds: 00 load, 01 store, 10 fetch, 11 treated as load.
  - A load needs rights other than 00. A store needs rights 10. A fetch needs rights 11.
  - A forbidden access raises `lk_fault` instead of `lk_hit` and drives `lk_ppn` to 0.
- R5: A faulting lookup changes neither the reference flags nor the dirty flags.
- R6: A permitted store hit sets the dirty flag of the matching way.
- R7: A permitted hit sets the reference flag of its way, and so does a refill. When this would leave all four reference flags of the set at 1, the other three are cleared.
- R8: A refill uses the lowest-numbered invalid way of its set. If every way is valid, it uses the lowest-numbered way whose reference flag is 0.
- R9: One cycle after a refill, the block reports the displaced entry:
  - `evict_valid` is 1 if the overwritten way held a valid entry.
  - `evict_dirty`, `evict_vpn` and `evict_ppn` describe that entry.
  - A refill whose page number is already present overwrites that way instead of the victim, so no tag is ever held twice in a set.
- R10: A flush clears every valid flag in one cycle. Every later lookup misses until entries are refilled.
- R11: Requests in the same cycle are served in priority order: flush, then refill, then lookup. A lower-priority request in that cycle has no effect and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_kind | input | 2 | Access kind (00 load, 01 store, 10 fetch, 11 load) |
| lk_hit | output | 1 | Permitted match for the previous lookup |
| lk_miss | output | 1 | No match for the previous lookup |
| lk_fault | output | 1 | Match whose rights forbid the access |
| lk_ppn | output | 18 | Physical page number on a hit, else 0 |
| fill_req | input | 1 | Refill request |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 18 | Physical page number to install |
| fill_rights | input | 2 | Rights code to install |
| evict_valid | output | 1 | The refill displaced a valid entry |
| evict_dirty | output | 1 | The displaced entry was dirty |
| evict_vpn | output | 20 | Virtual page number of the displaced entry |
| evict_ppn | output | 18 | Physical page number of the displaced entry |

## Verification
The assertions assume the following about the block's inputs:
- Reset is held low before the first request.
- Every input is stable across the rising edge at which it is sampled.
- Entries only ever enter the table through the refill port, which underpins the single-match check.

The bench drives all requests on the falling edge and holds them for exactly one rising edge. It reads the results on the next falling edge. It issues simultaneous requests only in the priority scenario, where the dropped request is then shown to have had no effect through later lookups and refills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RIGHTS_NONE = 2'b00,
        RIGHTS_RO   = 2'b01,
        RIGHTS_RW   = 2'b10,
        RIGHTS_EXEC = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_ALT   = 2'b11
    } access_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOOKUP,
        OP_FILL,
        OP_FLUSH
    } op_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_FAULT,
        RS_FILLED,
        RS_FLUSHED
    } result_e;

    // Permission of one access kind against one rights code.
    function automatic logic rights_allow(input rights_e r, input access_e a);
        logic ok;
        case (a)
            ACC_STORE: ok = (r == RIGHTS_RW);
            ACC_FETCH: ok = (r == RIGHTS_EXEC);
            default:   ok = (r != RIGHTS_NONE);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 16,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WAYS-1:0]              valid,
    input  logic [WAYS-1:0][TAG_W-1:0]   tags,
    input  logic [TAG_W-1:0]             tag_in,
    output logic [WAYS-1:0]              hit_vec,
    output logic                         hit_any,
    output logic [WIDX-1:0]              hit_idx
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid[w] && (tags[w] == tag_in);
    end

    assign hit_any = |hit_vec;

    // Lowest-numbered match wins (only one can exist, see assertion).
    always_comb begin
        hit_idx = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_idx = WIDX'(w);
            end
        end
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R9

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
    parameter int WAYS = 4,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] refb,
    output logic [WIDX-1:0] victim
);

    logic found;

    always_comb begin
        victim = '0;
        found  = 1'b0;
        // First choice: an empty way.
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid[w]) begin
                victim = WIDX'(w);
                found  = 1'b1;
            end
        end
        // Second choice: a way not referenced since the last clearing.
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !refb[w]) begin
                victim = WIDX'(w);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush,
    input  logic    fill_req,
    input  logic    lk_req,
    input  logic    lk_match,
    input  logic    lk_allow,
    input  logic    lk_store,
    output op_e     op,
    output logic    touch,
    output logic    mark_dirty,
    output logic    res_hit,
    output logic    res_miss,
    output logic    res_fault,
    output logic    res_evict
);

    result_e st_q, st_d;

    // Fixed priority among simultaneous requests.
    always_comb begin
        if (flush)         op = OP_FLUSH;
        else if (fill_req) op = OP_FILL;
        else if (lk_req)   op = OP_LOOKUP;
        else               op = OP_NONE;
    end

    assign touch      = (op == OP_LOOKUP) && lk_match && lk_allow;
    assign mark_dirty = touch && lk_store;

    always_comb begin
        st_d = RS_IDLE;
        unique case (op)
            OP_FLUSH:  st_d = RS_FLUSHED;
            OP_FILL:   st_d = RS_FILLED;
            OP_LOOKUP: begin
                if (!lk_match)     st_d = RS_MISS;
                else if (lk_allow) st_d = RS_HIT;
                else               st_d = RS_FAULT;
            end
            OP_NONE:   st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        res_hit   = 1'b0;
        res_miss  = 1'b0;
        res_fault = 1'b0;
        res_evict = 1'b0;
        unique case (st_q)
            RS_HIT:     res_hit   = 1'b1;
            RS_MISS:    res_miss  = 1'b1;
            RS_FAULT:   res_fault = 1'b1;
            RS_FILLED:  res_evict = 1'b1;
            RS_IDLE, RS_FLUSHED: ;
            default: ;
        endcase
    end

    AST_FILL_WINS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && lk_req && !flush) |=> (!res_hit && !res_miss && !res_fault)); // R11
    AST_FLUSH_WINS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!res_evict && !res_hit && !res_miss && !res_fault)); // R11

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 18,
    parameter int ENTRIES = 64,
    parameter int WAYS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PPN_W-1:0]  lk_ppn,
    input  logic              fill_req,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [1:0]        fill_rights,
    output logic              evict_valid,
    output logic              evict_dirty,
    output logic [VPN_W-1:0]  evict_vpn,
    output logic [PPN_W-1:0]  evict_ppn
);

    localparam int SETS  = ENTRIES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WIDX  = $clog2(WAYS);

    // ---------------- state and payload storage ----------------
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  ref_q   [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [PPN_W-1:0] ppn_q   [SETS][WAYS];
    logic [1:0]       rgt_q   [SETS][WAYS];

    // ---------------- address split ----------------
    logic [IDX_W-1:0] lk_idx, fl_idx;
    logic [TAG_W-1:0] lk_tag, fl_tag;

    assign lk_idx = lk_vpn[IDX_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
    assign fl_idx = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1:IDX_W];

    // ---------------- set read-out ----------------
    logic [WAYS-1:0][TAG_W-1:0] lk_tags, fl_tags;
    logic [WAYS-1:0][PPN_W-1:0] lk_ppns, fl_ppns;
    logic [WAYS-1:0][1:0]       lk_rgts;

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign lk_tags[w] = tag_q[lk_idx][w];
        assign lk_ppns[w] = ppn_q[lk_idx][w];
        assign lk_rgts[w] = rgt_q[lk_idx][w];
        assign fl_tags[w] = tag_q[fl_idx][w];
        assign fl_ppns[w] = ppn_q[fl_idx][w];
    end

    // ---------------- tag match ----------------
    logic [WAYS-1:0] lk_hit_vec, fl_hit_vec;
    logic            lk_match, fl_dup;
    logic [WIDX-1:0] lk_way, fl_dup_way;

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid_q[lk_idx]),
        .tags    (lk_tags),
        .tag_in  (lk_tag),
        .hit_vec (lk_hit_vec),
        .hit_any (lk_match),
        .hit_idx (lk_way)
    );

    tlb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (valid_q[fl_idx]),
        .tags    (fl_tags),
        .tag_in  (fl_tag),
        .hit_vec (fl_hit_vec),
        .hit_any (fl_dup),
        .hit_idx (fl_dup_way)
    );

    // ---------------- victim choice ----------------
    logic [WIDX-1:0] victim_way, fill_way;

    tlb_victim_pick #(.WAYS(WAYS)) u_victim (
        .valid  (valid_q[fl_idx]),
        .refb   (ref_q[fl_idx]),
        .victim (victim_way)
    );

    // A page already present is refreshed in place.
    assign fill_way = fl_dup ? fl_dup_way : victim_way;

    // ---------------- permission and control ----------------
    logic lk_allow, lk_store;
    op_e  op;
    logic touch, mark_dirty;
    logic res_hit, res_miss, res_fault, res_evict;

    assign lk_allow = rights_allow(rights_e'(lk_rgts[lk_way]), access_e'(lk_kind));
    assign lk_store = (access_e'(lk_kind) == ACC_STORE);

    tlb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_req   (fill_req),
        .lk_req     (lk_req),
        .lk_match   (lk_match),
        .lk_allow   (lk_allow),
        .lk_store   (lk_store),
        .op         (op),
        .touch      (touch),
        .mark_dirty (mark_dirty),
        .res_hit    (res_hit),
        .res_miss   (res_miss),
        .res_fault  (res_fault),
        .res_evict  (res_evict)
    );

    // ---------------- reference-flag update ----------------
    logic [WAYS-1:0] lk_sel, lk_ref_nxt, fl_sel, fl_ref_nxt;

    always_comb begin
        lk_sel = '0;
        lk_sel[lk_way] = 1'b1;
        lk_ref_nxt = ref_q[lk_idx] | lk_sel;
        if (&lk_ref_nxt) lk_ref_nxt = lk_sel;

        fl_sel = '0;
        fl_sel[fill_way] = 1'b1;
        fl_ref_nxt = ref_q[fl_idx] | fl_sel;
        if (&fl_ref_nxt) fl_ref_nxt = fl_sel;
    end

    // ---------------- flag and result registers ----------------
    logic [PPN_W-1:0] ppn_r;
    logic             ev_valid_r, ev_dirty_r;
    logic [VPN_W-1:0] ev_vpn_r;
    logic [PPN_W-1:0] ev_ppn_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                ref_q[s]   <= '0;
                dirty_q[s] <= '0;
            end
            ppn_r      <= '0;
            ev_valid_r <= 1'b0;
            ev_dirty_r <= 1'b0;
            ev_vpn_r   <= '0;
            ev_ppn_r   <= '0;
        end else begin
            unique case (op)
                OP_FLUSH: begin
                    for (int s = 0; s < SETS; s++) begin
                        valid_q[s] <= '0;
                    end
                end
                OP_FILL: begin
                    ev_valid_r <= valid_q[fl_idx][fill_way];
                    ev_dirty_r <= valid_q[fl_idx][fill_way] && dirty_q[fl_idx][fill_way];
                    ev_vpn_r   <= {fl_tags[fill_way], fl_idx};
                    ev_ppn_r   <= fl_ppns[fill_way];
                    valid_q[fl_idx][fill_way] <= 1'b1;
                    dirty_q[fl_idx][fill_way] <= 1'b0;
                    ref_q[fl_idx]             <= fl_ref_nxt;
                end
                OP_LOOKUP: begin
                    ppn_r <= lk_ppns[lk_way];
                    if (touch) begin
                        ref_q[lk_idx] <= lk_ref_nxt;
                    end
                    if (mark_dirty) begin
                        dirty_q[lk_idx][lk_way] <= 1'b1;
                    end
                end
                OP_NONE: ;
            endcase
        end
    end

    // Payload carries no reset: valid flags qualify it.
    always_ff @(posedge clk) begin
        if (op == OP_FILL) begin
            tag_q[fl_idx][fill_way] <= fl_tag;
            ppn_q[fl_idx][fill_way] <= fill_ppn;
            rgt_q[fl_idx][fill_way] <= fill_rights;
        end
    end

    // ---------------- outputs ----------------
    assign lk_hit      = res_hit;
    assign lk_miss     = res_miss;
    assign lk_fault    = res_fault;
    assign lk_ppn      = res_hit ? ppn_r : '0;
    assign evict_valid = res_evict && ev_valid_r;
    assign evict_dirty = res_evict && ev_dirty_r;
    assign evict_vpn   = (res_evict && ev_valid_r) ? ev_vpn_r : '0;
    assign evict_ppn   = (res_evict && ev_valid_r) ? ev_ppn_r : '0;

    // ---------------- assertions ----------------
    logic [ENTRIES-1:0] valid_flat, ref_flat, dirty_flat;

    for (genvar s = 0; s < SETS; s++) begin : g_flat
        assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
        assign ref_flat[s*WAYS +: WAYS]   = ref_q[s];
        assign dirty_flat[s*WAYS +: WAYS] = dirty_q[s];

        AST_REF_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n) !(&ref_q[s])); // R7
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_flat == '0)); // R10
    AST_FAULT_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> $stable(dirty_flat)); // R5
    AST_FAULT_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> $stable(ref_flat)); // R5
    AST_MISS_NO_PPN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_fault) |-> (lk_ppn == '0)); // R3
    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        evict_dirty |-> evict_valid); // R9

endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [17:0] lk_ppn;
    logic        fill_req = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [17:0] fill_ppn = '0;
    logic [1:0]  fill_rights = '0;
    logic        evict_valid, evict_dirty;
    logic [19:0] evict_vpn;
    logic [17:0] evict_ppn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tlb_xlate u_dut (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .lk_req (lk_req), .lk_vpn (lk_vpn), .lk_kind (lk_kind),
        .lk_hit (lk_hit), .lk_miss (lk_miss), .lk_fault (lk_fault), .lk_ppn (lk_ppn),
        .fill_req (fill_req), .fill_vpn (fill_vpn), .fill_ppn (fill_ppn), .fill_rights (fill_rights),
        .evict_valid (evict_valid), .evict_dirty (evict_dirty),
        .evict_vpn (evict_vpn), .evict_ppn (evict_ppn)
    );

    localparam logic [2:0] C_HIT = 3'b100, C_MISS = 3'b010, C_FAULT = 3'b001, C_NONE = 3'b000;
    localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_FE = 2'b10, K_ALT = 2'b11;
    localparam logic [1:0] P_NONE = 2'b00, P_RO = 2'b01, P_RW = 2'b10, P_EX = 2'b11;

    logic [2:0]  r_code;
    logic [17:0] r_ppn;
    logic        e_v, e_d;
    logic [19:0] e_vpn;
    logic [17:0] e_ppn;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] va(input int tag, input int set);
        return 20'((tag << 4) | set);
    endfunction

    // One request cycle: drive on falling edge, sample on the next one.
    task automatic cycle(input logic l, input logic [19:0] lv, input logic [1:0] k,
                         input logic f, input logic [19:0] fv, input logic [17:0] fp,
                         input logic [1:0] fr, input logic fl);
        @(negedge clk);
        lk_req = l; lk_vpn = lv; lk_kind = k;
        fill_req = f; fill_vpn = fv; fill_ppn = fp; fill_rights = fr;
        flush = fl;
        @(negedge clk);
        r_code = {lk_hit, lk_miss, lk_fault};
        r_ppn  = lk_ppn;
        e_v = evict_valid; e_d = evict_dirty; e_vpn = evict_vpn; e_ppn = evict_ppn;
        lk_req = 1'b0; fill_req = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input string req, input logic [19:0] v, input logic [1:0] k,
                        input logic [2:0] code, input logic [17:0] ppn);
        cycle(1'b1, v, k, 1'b0, '0, '0, '0, 1'b0);
        check(req, "result code", 32'(r_code), 32'(code));
        check(req, "ppn", 32'(r_ppn), 32'(ppn));
    endtask

    task automatic fill(input string req, input logic [19:0] v, input logic [17:0] p,
                        input logic [1:0] rg, input logic ev, input logic ed,
                        input logic [19:0] evpn, input logic [17:0] eppn);
        cycle(1'b0, '0, '0, 1'b1, v, p, rg, 1'b0);
        check(req, "evict_valid", 32'(e_v), 32'(ev));
        check(req, "evict_dirty", 32'(e_d), 32'(ed));
        if (ev) begin
            check(req, "evict_vpn", 32'(e_vpn), 32'(evpn));
            check(req, "evict_ppn", 32'(e_ppn), 32'(eppn));
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "flags in reset", 32'({lk_hit, lk_miss, lk_fault, evict_valid, evict_dirty}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after reset", 32'({lk_hit, lk_miss, lk_fault, evict_valid}), 32'h0);
        look("R1", 20'h00012, K_LD, C_MISS, '0);
        look("R3", 20'hFFFF3, K_ST, C_MISS, '0);
    endtask

    task automatic t_basic();
        fill("R9", 20'h00123, 18'h0ABC, P_RW, 1'b0, 1'b0, '0, '0);
        look("R2", 20'h00123, K_LD, C_HIT, 18'h0ABC);
        look("R4", 20'h00123, K_ST, C_HIT, 18'h0ABC);
        look("R4", 20'h00123, K_FE, C_FAULT, '0);
        look("R3", 20'h00133, K_LD, C_MISS, '0);
    endtask

    task automatic t_rights();
        fill("R4", 20'h00204, 18'h1111, P_RO, 1'b0, 1'b0, '0, '0);
        look("R4", 20'h00204, K_LD, C_HIT, 18'h1111);
        look("R4", 20'h00204, K_ST, C_FAULT, '0);
        look("R4", 20'h00204, K_ALT, C_HIT, 18'h1111);
        look("R4", 20'h00204, K_FE, C_FAULT, '0);
        fill("R4", 20'h00305, 18'h2222, P_EX, 1'b0, 1'b0, '0, '0);
        look("R4", 20'h00305, K_FE, C_HIT, 18'h2222);
        look("R4", 20'h00305, K_LD, C_HIT, 18'h2222);
        look("R4", 20'h00305, K_ST, C_FAULT, '0);
        fill("R4", 20'h00406, 18'h3333, P_NONE, 1'b0, 1'b0, '0, '0);
        look("R4", 20'h00406, K_LD, C_FAULT, '0);
        look("R4", 20'h00406, K_FE, C_FAULT, '0);
        look("R3", 20'h00504, K_LD, C_MISS, '0);
    endtask

    task automatic t_replace();
        for (int t = 1; t <= 4; t++) begin
            fill("R8", va(t, 7), 18'(32'h100 + t), P_RW, 1'b0, 1'b0, '0, '0);
        end
        look("R6", va(2, 7), K_ST, C_HIT, 18'h102);
        look("R7", va(1, 7), K_LD, C_HIT, 18'h101);
        // refs now 1011 -> way2 (tag 3) is the victim
        fill("R7", va(5, 7), 18'h105, P_RW, 1'b1, 1'b0, va(3, 7), 18'h103);
        // refs cleared to 0100 -> way0 (tag 1)
        fill("R8", va(6, 7), 18'h106, P_RW, 1'b1, 1'b0, va(1, 7), 18'h101);
        // refs 0101 -> way1 (tag 2, dirty)
        fill("R6", va(7, 7), 18'h107, P_RW, 1'b1, 1'b1, va(2, 7), 18'h102);
        look("R3", va(3, 7), K_LD, C_MISS, '0);
        look("R9", va(5, 7), K_LD, C_HIT, 18'h105);
    endtask

    task automatic t_fault_untouched();
        for (int t = 1; t <= 4; t++) begin
            fill("R8", va(t, 8), 18'(32'h200 + t), P_RO, 1'b0, 1'b0, '0, '0);
        end
        // refs 1000; a faulting store must neither reference nor dirty way0
        look("R5", va(1, 8), K_ST, C_FAULT, '0);
        fill("R5", va(5, 8), 18'h205, P_RW, 1'b1, 1'b0, va(1, 8), 18'h201);
    endtask

    task automatic t_duplicate();
        fill("R9", va(1, 9), 18'h301, P_RW, 1'b0, 1'b0, '0, '0);
        fill("R9", va(1, 9), 18'h302, P_RW, 1'b1, 1'b0, va(1, 9), 18'h301);
        look("R9", va(1, 9), K_LD, C_HIT, 18'h302);
        fill("R8", va(2, 9), 18'h303, P_RW, 1'b0, 1'b0, '0, '0);
        look("R2", va(2, 9), K_LD, C_HIT, 18'h303);
    endtask

    task automatic t_priority_flush();
        // refill beats lookup
        cycle(1'b1, 20'h00123, K_LD, 1'b1, 20'h0000A, 18'h0400, P_RW, 1'b0);
        check("R11", "lookup dropped", 32'(r_code), 32'(C_NONE));
        check("R11", "fill evict_valid", 32'(e_v), 32'h0);
        look("R11", 20'h0000A, K_LD, C_HIT, 18'h0400);
        look("R11", 20'h00123, K_LD, C_HIT, 18'h0ABC);
        // flush beats refill
        cycle(1'b0, '0, K_LD, 1'b1, 20'h0001B, 18'h0500, P_RW, 1'b1);
        check("R11", "flush cycle flags", 32'({r_code, e_v}), 32'h0);
        look("R11", 20'h0001B, K_LD, C_MISS, '0);
        look("R10", 20'h00123, K_LD, C_MISS, '0);
        look("R10", 20'h0000A, K_LD, C_MISS, '0);
        look("R10", va(5, 7), K_LD, C_MISS, '0);
        fill("R10", va(9, 7), 18'h109, P_RW, 1'b0, 1'b0, '0, '0);
        look("R10", va(9, 7), K_LD, C_HIT, 18'h109);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_rights();
        t_replace();
        t_fault_untouched();
        t_duplicate();
        t_priority_flush();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule